// File: doc/BRIEF.md
# Background ECC Scrubber

The block runs beside an error-correcting on-chip RAM and sweeps through it when nothing else needs it. Leaving reset, it writes zero data with valid check bits to every word, one word per cycle and with no wait between writes. After that it scrubs in bursts. Each burst reads four adjacent words and then writes them back. A word with one flipped bit is written back repaired. A word with two flipped bits is written back exactly as it was read and is reported.

A delay setting, in units of 1024 cycles, sets how long the scrubber waits between bursts. An enable input pauses and resumes the sweep without losing its place. A functional master asks for a sub-bank with a request and a bank index. While a burst owns that sub-bank, the request is not granted, so the master stalls. Scrubber writes happen inside the memory subsystem, so they never pass through the bus access-protection checks.

Top module: `scrub_engine`

## Requirements
- R1: After reset the block writes every address once, in ascending order, on consecutive cycles, with data zero and the check bits of zero. `init_done` then rises. No master request is granted before `init_done`.
- R2: Bursts scrub addresses in ascending order, starting at address 0 after the initialization pass and wrapping from the highest address back to 0.
- R3: A burst is four reads of four consecutive addresses on four consecutive cycles. The next four cycles write the same four addresses in the same order.
- R4: With the scrubber enabled and delay setting D (sampled when a burst ends), exactly D*1024 idle cycles separate the last write of a burst from the first read of the next. With D = 0, the next read follows in the very next cycle.
- R5: While `scrub_en` is low, no new burst starts. When it is raised again, scrubbing continues at the address after the last one scrubbed.
- R6: A word with a single flipped bit, whether in data or in check bits, is written back with the original data and correct check bits. `corr_pulse` pulses once for that word.
- R7: A word with two flipped bits is written back unchanged. `uncorr_pulse` pulses once for that word and `corr_pulse` stays low.
- R8: `corr_count` is zero after reset. It increases by one for each corrected word and holds at its all-ones value.
- R9: While a burst is running, a master request whose bank index equals the top two address bits of the burst is not granted. Requests to other banks are granted. No request means no grant.
- R10: The code works as follows. Data bit j sits at Hamming position p(j), the j-th integer at least 3 that is not a power of two. Check bit i (i < 5) is the XOR of the data bits whose position has bit i set. Check bit 5 is the XOR of all data bits and check bits 0 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scrub_en | input | 1 | Allows bursts to start |
| ref_delay | input | 4 | Wait between bursts, in units of 1024 cycles |
| mem_req | output | 1 | RAM access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 6 | RAM word address |
| mem_wdata | output | 16 | Write data |
| mem_wchk | output | 6 | Write check bits |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| mem_rchk | input | 6 | Read check bits, valid the cycle after a read |
| mst_req | input | 1 | Functional master request |
| mst_bank | input | 2 | Sub-bank the master wants |
| mst_gnt | output | 1 | Grant to the master |
| init_done | output | 1 | Initialization pass complete |
| corr_pulse | output | 1 | One-cycle pulse per corrected word |
| uncorr_pulse | output | 1 | One-cycle pulse per uncorrectable word |
| corr_count | output | 8 | Saturating count of corrected words |

## Verification
A wrong sweep pointer shows at the RAM port straight away. The next burst reads an address out of sequence, or writes one that does not match its reads. A wrong capture slot or a bad decoder shows four cycles later at the latest, as write-back data or check bits that differ from the clean word. A pacing counter that reloads wrongly or never expires shows as a wrong idle gap at the following burst. A lost bank lock shows as a grant in the same cycle as a read or write to the master's bank.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    localparam int DATA_W     = 16;
    localparam int HAM_W      = 5;
    localparam int CHK_W      = HAM_W + 1;
    localparam int ADDR_W     = 6;
    localparam int BANK_W     = 2;
    localparam int BURST_LEN  = 4;
    localparam int BURST_W    = $clog2(BURST_LEN);
    localparam int STEP_W     = BURST_W + 1;
    localparam int DLY_W      = 4;
    localparam int PRESCALE_W = 10;
    localparam int WAIT_W     = DLY_W + PRESCALE_W;
    localparam int CNT_W      = 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
    } cword_t;

    typedef enum logic [1:0] {ST_START, ST_INIT, ST_WAIT, ST_BURST} scrub_st_t;

    // Hamming position of data bit j: j-th non-power-of-two integer from 3
    function automatic int data_pos(input int j);
        int n;
        int pos;
        n = 0;
        pos = 0;
        for (int q = 3; q < 64; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (n == j) pos = q;
                n++;
            end
        end
        return pos;
    endfunction

    function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        int p;
        h = '0;
        for (int j = 0; j < DATA_W; j++) begin
            p = data_pos(j);
            for (int i = 0; i < HAM_W; i++) begin
                if (p[i]) h[i] = h[i] ^ d[j];
            end
        end
        return h;
    endfunction

    function automatic logic [CHK_W-1:0] encode(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        h = ham_bits(d);
        return {^{d, h}, h};
    endfunction
endpackage

// File: rtl/scrub_ecc.sv
module scrub_ecc
    import scrub_pkg::*;
(
    input  cword_t raw,
    output cword_t fixed,
    output logic   single_err,
    output logic   double_err
);
    logic [HAM_W-1:0]  syn;
    logic              par_bad;
    logic [DATA_W-1:0] dfix;

    always_comb begin
        syn        = ham_bits(raw.data) ^ raw.chk[HAM_W-1:0];
        par_bad    = ^{raw.data, raw.chk};
        single_err = par_bad;
        double_err = !par_bad && (syn != '0);
        dfix       = raw.data;
        for (int j = 0; j < DATA_W; j++) begin
            if (par_bad && (data_pos(j) == int'(syn))) dfix[j] = ~raw.data[j];
        end
        fixed = raw;
        if (par_bad) begin
            fixed.data = dfix;
            fixed.chk  = encode(dfix);
        end
    end
endmodule

// File: rtl/scrub_pacer.sv
module scrub_pacer
    import scrub_pkg::*;
#(
    parameter int DW = DLY_W,
    parameter int PW = PRESCALE_W,
    localparam int CW = DW + PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] delay,
    input  logic          tick,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (delay == '0) ? '0 : ({delay, {PW{1'b0}}} - CW'(1));
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/scrub_bank_lock.sv
module scrub_bank_lock
    import scrub_pkg::*;
(
    input  logic              hold_all,
    input  logic              lock_on,
    input  logic [BANK_W-1:0] lock_bank,
    input  logic              mst_req,
    input  logic [BANK_W-1:0] mst_bank,
    output logic              mst_gnt
);
    logic clash;

    always_comb begin
        clash   = lock_on && (mst_bank == lock_bank);
        mst_gnt = mst_req && !hold_all && !clash;
    end
endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
    import scrub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scrub_en,
    input  logic [DLY_W-1:0]  ref_delay,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [CHK_W-1:0]  mem_wchk,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [CHK_W-1:0]  mem_rchk,
    input  logic              mst_req,
    input  logic [BANK_W-1:0] mst_bank,
    output logic              mst_gnt,
    output logic              init_done,
    output logic              corr_pulse,
    output logic              uncorr_pulse,
    output logic [CNT_W-1:0]  corr_count
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(2 * BURST_LEN - 1);

    scrub_st_t          st_q, st_d;
    logic [STEP_W-1:0]  step_q;
    logic [ADDR_W-1:0]  ptr_q;
    cword_t             buf_q [BURST_LEN];
    logic               rd_vld_q;
    logic [BURST_W-1:0] rd_idx_q;
    logic               init_done_q, corr_q, uncorr_q;
    logic [CNT_W-1:0]   cnt_q;

    logic   in_burst, in_init, last_step, end_ev, go_now, expired;
    cword_t rd_word, fix_word;
    logic   fix_single, fix_double;

    always_comb begin
        in_burst  = (st_q == ST_BURST);
        in_init   = (st_q == ST_INIT);
        last_step = (step_q == LAST_STEP);
        end_ev    = (in_init && (ptr_q == '1)) || (in_burst && last_step);
        go_now    = scrub_en && (ref_delay == '0);
        rd_word   = '{data: mem_rdata, chk: mem_rchk};
    end

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_START: st_d = ST_INIT;
            ST_INIT, ST_BURST: if (end_ev) st_d = go_now ? ST_BURST : ST_WAIT;
            ST_WAIT:  if (scrub_en && expired) st_d = ST_BURST;
            default:  st_d = ST_START;
        endcase
    end

    scrub_pacer u_pacer (
        .clk     (clk),
        .rst     (rst),
        .load    (end_ev),
        .delay   (ref_delay),
        .tick    ((st_q == ST_WAIT) && scrub_en),
        .expired (expired)
    );

    scrub_ecc u_ecc (
        .raw        (rd_word),
        .fixed      (fix_word),
        .single_err (fix_single),
        .double_err (fix_double)
    );

    scrub_bank_lock u_lock (
        .hold_all  (!init_done_q),
        .lock_on   (in_burst),
        .lock_bank (ptr_q[ADDR_W-1 -: BANK_W]),
        .mst_req   (mst_req),
        .mst_bank  (mst_bank),
        .mst_gnt   (mst_gnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_START;
            step_q      <= '0;
            ptr_q       <= '0;
            rd_vld_q    <= 1'b0;
            rd_idx_q    <= '0;
            init_done_q <= 1'b0;
            corr_q      <= 1'b0;
            uncorr_q    <= 1'b0;
            cnt_q       <= '0;
        end else begin
            st_q     <= st_d;
            step_q   <= in_burst ? step_q + STEP_W'(1) : '0;
            if (in_init) begin
                ptr_q <= ptr_q + ADDR_W'(1);
            end else if (in_burst && last_step) begin
                ptr_q <= ptr_q + ADDR_W'(BURST_LEN);
            end
            if (in_init && end_ev) init_done_q <= 1'b1;
            rd_vld_q <= in_burst && !step_q[BURST_W];
            rd_idx_q <= step_q[BURST_W-1:0];
            corr_q   <= rd_vld_q && fix_single;
            uncorr_q <= rd_vld_q && fix_double;
            if (rd_vld_q && fix_single && (cnt_q != '1)) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rd_vld_q) buf_q[rd_idx_q] <= fix_word;
    end

    always_comb begin
        mem_req   = in_init || in_burst;
        mem_we    = in_init || (in_burst && step_q[BURST_W]);
        mem_addr  = in_burst ? {ptr_q[ADDR_W-1:BURST_W], step_q[BURST_W-1:0]} : ptr_q;
        mem_wdata = in_init ? '0 : buf_q[step_q[BURST_W-1:0]].data;
        mem_wchk  = in_init ? encode('0) : buf_q[step_q[BURST_W-1:0]].chk;
    end

    assign init_done    = init_done_q;
    assign corr_pulse   = corr_q;
    assign uncorr_pulse = uncorr_q;
    assign corr_count   = cnt_q;
endmodule

// File: rtl/scrub_engine_chk.sv
module scrub_engine_chk
    import scrub_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scrub_en,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mst_req,
    input logic [BANK_W-1:0] mst_bank,
    input logic              mst_gnt,
    input logic              init_done,
    input logic              corr_pulse,
    input logic              uncorr_pulse,
    input logic [CNT_W-1:0]  corr_count
);
    AST_INIT_NO_GNT: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !mst_gnt); // R1

    AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && $past(mem_req && !mem_we))
        |-> (mem_addr == $past(mem_addr) + ADDR_W'(1))); // R3

    AST_WR_START: assert property (@(posedge clk) disable iff (rst)
        (init_done && mem_req && mem_we && !$past(mem_req && mem_we))
        |-> ($past(mem_req && !mem_we) && ((mem_addr + ADDR_W'(3)) == $past(mem_addr)))); // R3

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (init_done && !scrub_en && !mem_req) |=> !mem_req); // R5

    AST_BANK_LOCK: assert property (@(posedge clk) disable iff (rst)
        (init_done && mem_req && mst_req && (mst_bank == mem_addr[ADDR_W-1 -: BANK_W]))
        |-> !mst_gnt); // R9

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(corr_pulse && uncorr_pulse)); // R7

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(corr_count) == '1) |-> (corr_count == '1)); // R8

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (corr_pulse && ($past(corr_count) != '1))
        |-> (corr_count == $past(corr_count) + CNT_W'(1))); // R8
endmodule

bind scrub_engine scrub_engine_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .scrub_en     (scrub_en),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mst_req      (mst_req),
    .mst_bank     (mst_bank),
    .mst_gnt      (mst_gnt),
    .init_done    (init_done),
    .corr_pulse   (corr_pulse),
    .uncorr_pulse (uncorr_pulse),
    .corr_count   (corr_count)
);

// File: tb/scrub_engine_test.sv
`timescale 1ns/1ps
module scrub_engine_test;
    import scrub_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              scrub_en = 1'b0;
    logic [DLY_W-1:0]  ref_delay = '0;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic [CHK_W-1:0]  mem_wchk, mem_rchk;
    logic              mst_req = 1'b0;
    logic [BANK_W-1:0] mst_bank = '0;
    logic              mst_gnt, init_done, corr_pulse, uncorr_pulse;
    logic [CNT_W-1:0]  corr_count;

    always #4 clk = ~clk;

    scrub_engine uut (.*);

    // ---------------- RAM model with a backdoor port ----------------
    logic [DATA_W-1:0] ram_d [DEPTH];
    logic [CHK_W-1:0]  ram_c [DEPTH];
    logic              bd_we = 1'b0;
    logic [ADDR_W-1:0] bd_a = '0;
    logic [DATA_W-1:0] bd_d = '0;
    logic [CHK_W-1:0]  bd_c = '0;

    initial begin
        mem_rdata = '0;
        mem_rchk  = '0;
    end

    always @(posedge clk) begin
        if (bd_we) begin
            ram_d[bd_a] <= bd_d;
            ram_c[bd_a] <= bd_c;
        end else if (mem_req) begin
            if (mem_we) begin
                ram_d[mem_addr] <= mem_wdata;
                ram_c[mem_addr] <= mem_wchk;
            end else begin
                mem_rdata <= ram_d[mem_addr];
                mem_rchk  <= ram_c[mem_addr];
            end
        end
    end

    // ---------------- bookkeeping ----------------
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=0x%0h exp=0x%0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // independent encoder, walking codeword positions (R10)
    function automatic logic [CHK_W-1:0] tb_enc(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        int k;
        h = '0;
        k = 0;
        for (int p = 1; p <= DATA_W + HAM_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int i = 0; i < HAM_W; i++) if (p[i]) h[i] = h[i] ^ d[k];
                k++;
            end
        end
        return {^{d, h}, h};
    endfunction

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        logic [CHK_W-1:0]  c;
        string             rq;
    } exp_t;

    exp_t              sb_q[$];
    logic [DATA_W-1:0] exp_d [DEPTH];
    logic [CHK_W-1:0]  exp_c [DEPTH];
    string             exp_rq [DEPTH];
    logic [ADDR_W-1:0] plan_ptr = '0;

    task automatic plan(input int n);
        for (int i = 0; i < n; i++) begin
            sb_q.push_back('{a: plan_ptr, d: exp_d[plan_ptr], c: exp_c[plan_ptr], rq: exp_rq[plan_ptr]});
            plan_ptr = plan_ptr + ADDR_W'(1);
        end
    endtask

    // ---------------- monitor ----------------
    int                init_cnt = 0;
    logic [ADDR_W-1:0] nxt_rd = '0;
    int                pos = 0, last_cyc = 0, exp_gap = -1;
    bit                first_b = 1;
    int                n_corr = 0, n_unc = 0;
    exp_t              it;

    always @(negedge clk) begin
        if (!rst) begin
            if (corr_pulse) n_corr++;
            if (uncorr_pulse) n_unc++;
            if (mem_req && !init_done) begin
                check(mem_we && (mem_addr == ADDR_W'(init_cnt)), "R1 init write order",
                      mem_addr, init_cnt);
                check(mem_wdata == '0 && mem_wchk == tb_enc('0), "R1 R10 init word",
                      {mem_wdata, mem_wchk}, {16'h0, tb_enc('0)});
                init_cnt++;
            end else if (mem_req && !mem_we) begin
                check(mem_addr == nxt_rd, "R2 scrub read address", mem_addr, nxt_rd);
                nxt_rd = nxt_rd + ADDR_W'(1);
                if (pos == 0) begin
                    if (!first_b && exp_gap >= 0)
                        check(cyc - last_cyc - 1 == exp_gap, "R4 idle gap", cyc - last_cyc - 1, exp_gap);
                    first_b = 0;
                end else begin
                    check(pos < BURST_LEN && cyc == last_cyc + 1, "R3 read slot", pos, cyc - last_cyc);
                end
                last_cyc = cyc;
                pos = (pos + 1) % (2 * BURST_LEN);
            end else if (mem_req && mem_we) begin
                check(pos >= BURST_LEN && cyc == last_cyc + 1, "R3 write slot", pos, cyc - last_cyc);
                last_cyc = cyc;
                pos = (pos + 1) % (2 * BURST_LEN);
                if (sb_q.size() == 0) begin
                    check(0, "R5 write with empty scoreboard", mem_addr, 0);
                end else begin
                    it = sb_q.pop_front();
                    check(mem_addr == it.a, "R3 write address", mem_addr, it.a);
                    check(mem_wdata == it.d, it.rq, mem_wdata, it.d);
                    check(mem_wchk == it.c, "R10 write-back check bits", mem_wchk, it.c);
                end
            end
        end
    end

    // ---------------- driver ----------------
    logic [DATA_W-1:0] gold [DEPTH];

    task automatic poke(input int a, input logic [DATA_W-1:0] d, input logic [CHK_W-1:0] c);
        @(negedge clk);
        bd_we = 1'b1;
        bd_a  = ADDR_W'(a);
        bd_d  = d;
        bd_c  = c;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic quiet(input int n, input string rq);
        int hits;
        hits = 0;
        repeat (n) begin
            @(negedge clk);
            if (mem_req) hits++;
        end
        check(hits == 0, rq, hits, 0);
    endtask

    task automatic run_phase(input int words, input logic [DLY_W-1:0] dly, input int gap);
        plan(words);
        ref_delay = dly;
        exp_gap   = gap;
        first_b   = 1;
        @(negedge clk);
        scrub_en = 1'b1;
        wait (sb_q.size() == 0);
        scrub_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=completion");
        finish_run();
    end

    initial begin
        logic [BANK_W-1:0] bk;
        int base_corr;
        repeat (4) @(negedge clk);
        check(!mem_req && !init_done && corr_count == 0 && !corr_pulse, "R1 R8 reset state",
              {mem_req, init_done, corr_count}, 0);
        rst = 1'b0;

        repeat (10) @(negedge clk);
        mst_req  = 1'b1;
        mst_bank = 2'd3;
        #1 check(!mst_gnt, "R1 grant held during init", mst_gnt, 0);
        mst_req = 1'b0;

        @(negedge clk iff init_done);
        check(init_cnt == DEPTH, "R1 init covers all words", init_cnt, DEPTH);
        quiet(200, "R5 no burst while disabled");

        // phase A: mixed error patterns, full sweep with D=0
        for (int a = 0; a < DEPTH; a++) begin
            gold[a]   = DATA_W'(a * 16'h1357) ^ 16'hA5A5;
            exp_d[a]  = gold[a];
            exp_c[a]  = tb_enc(gold[a]);
            exp_rq[a] = "R6 write-back data";
            if (a == 1)      poke(a, gold[a] ^ 16'h0080, tb_enc(gold[a]));
            else if (a == 2) poke(a, gold[a], tb_enc(gold[a]) ^ 6'h08);
            else if (a == 6) poke(a, gold[a], tb_enc(gold[a]) ^ 6'h20);
            else if (a == 5) begin
                poke(a, gold[a] ^ 16'h0201, tb_enc(gold[a]));
                exp_d[a]  = gold[a] ^ 16'h0201;
                exp_rq[a] = "R7 double error unchanged";
            end else poke(a, gold[a], tb_enc(gold[a]));
        end
        run_phase(DEPTH, 4'd0, 0);
        repeat (3) @(negedge clk);
        check(n_corr == 3, "R6 corrected pulses", n_corr, 3);
        check(n_unc == 1, "R7 uncorrectable pulses", n_unc, 1);
        check(corr_count == 3, "R8 counter value", corr_count, 3);

        // phase B: pacing D=1, resumes at address 0 after the wrap
        run_phase(12, 4'd1, 1024);
        quiet(100, "R5 paused mid-sweep");

        // phase C: pacing D=2 with the bank lock probe
        plan(8);
        ref_delay = 4'd2;
        exp_gap   = 2048;
        first_b   = 1;
        @(negedge clk);
        scrub_en = 1'b1;
        @(negedge clk iff (mem_req && !mem_we));
        bk = mem_addr[ADDR_W-1 -: BANK_W];
        mst_req  = 1'b1;
        mst_bank = bk;
        #1 check(!mst_gnt, "R9 locked bank stalled", mst_gnt, 0);
        mst_bank = bk + 2'd1;
        #1 check(mst_gnt, "R9 other bank granted", mst_gnt, 1);
        mst_req = 1'b0;
        #1 check(!mst_gnt, "R9 no request no grant", mst_gnt, 0);
        repeat (7) @(negedge clk);
        mst_req  = 1'b1;
        mst_bank = bk;
        #1 check(mem_we && !mst_gnt, "R9 lock on last write", mst_gnt, 0);
        @(negedge clk);
        #1 check(!mem_req && mst_gnt, "R9 lock released", mst_gnt, 1);
        mst_req = 1'b0;
        wait (sb_q.size() == 0);
        scrub_en = 1'b0;

        // phase D: back-to-back bursts
        run_phase(16, 4'd0, 0);

        // phase E: saturation, single errors in every word, four sweeps
        base_corr = n_corr;
        for (int r = 0; r < 4; r++) begin
            for (int a = 0; a < DEPTH; a++) begin
                exp_d[a]  = gold[a];
                exp_c[a]  = tb_enc(gold[a]);
                exp_rq[a] = "R6 write-back data";
                poke(a, gold[a] ^ DATA_W'(1 << (a % DATA_W)), tb_enc(gold[a]));
            end
            run_phase(DEPTH, 4'd0, 0);
            repeat (3) @(negedge clk);
            check(n_corr == base_corr + DEPTH * (r + 1), "R6 corrections per sweep",
                  n_corr, base_corr + DEPTH * (r + 1));
            if (r == 0) check(corr_count == 8'(3 + DEPTH), "R8 count after sweep", corr_count, 3 + DEPTH);
        end
        check(corr_count == 8'hFF, "R8 counter saturates", corr_count, 8'hFF);
        finish_run();
    end
endmodule